// File: doc/BRIEF.md
# Parallel Data Shifter with Status Flag

The block is one shifter of a configurable I/O peripheral. It moves 32-bit words between a software-visible buffer and a parallel pin bus, one beat per shift tick. An external timer supplies the shift ticks. In transmit mode the buffered word leaves on the pins, lowest bits first. In receive mode the pins, or the output of the neighbouring shifter, are sampled on every tick and assembled into a word that software then reads.

A single status flag does three jobs:
- Any access that hands the shifter new work clears it.
- While it is low it asks the external timer to run, through `timer_trig_o`.
- When interrupts are enabled it raises the interrupt.

The flag sets again when a word is finished. As a result the interrupt stays asserted after the final transfer until software clears the enable bit. Clearing the flag instead would start another shift sequence. A second, byte-reversed view of the buffer lets software put the upper byte of each 16-bit item on the bus first.

Top module: `pds_shifter`

## Requirements
- R1: After reset:
  - the shifter is in transmit mode with the flag set, so `timer_trig_o`, `irq_o` and `pin_oe_o` are 0;
  - the control register reads 0x70;
  - the interrupt enable register (address 2) reads 0.
- R2: A write to the buffer (address 3) in transmit mode loads the word and clears the flag. `timer_trig_o` is 1 whenever the flag is 0.
- R3: In transmit mode, after the load and after each of the following ticks, `pin_o` carries the next beat. Beat k is word bits [(k+1)B-1 : kB], where B is the beat width. Pins at or above B read 0.
- R4: After 32/B ticks the flag sets and `timer_trig_o` falls. Further ticks leave `pin_o` and the flag unchanged.
- R5: Control (address 0) is laid out as follows:
  - bit 0: receive mode;
  - bit 1: input from the neighbouring shifter;
  - bits [3:2]: pin direction;
  - bits [8:4]: width field, written as beat width minus one and clamped to PIN_W-1.
  Field values 0, 1, 3 and 7 give beats of 1, 2, 4 and 8 bits.
- R6: In receive mode each tick captures one beat from the input into the next higher bit slice, first beat lowest. After 32/B ticks the word is readable at address 3 and the flag sets. Ticks while the flag is set leave the captured word unchanged.
- R7: In receive mode a read of the buffer (address 3 or 4) clears the flag, which starts the next capture.
- R8: With control bit 1 set, receive data comes from `next_data_i` and `pin_i` is ignored.
- R9: `pin_oe_o` is 1 exactly when the pin direction field equals 3. A value of 0 means input.
- R10: Address 4 is a byte-reversed view of the buffer. A word written there goes out as bytes [31:24], [23:16], [15:8], [7:0]. A read there returns the captured word with its four bytes in reverse order.
- R11: `irq_o` is the flag ANDed with interrupt enable bit 0 (address 2). It stays asserted after a finished transfer until the enable is cleared.
- R12: Writing 1 to bit 0 of the status register (address 1) clears the flag. In transmit mode the buffered word is then shifted out again from its first beat.
- R13: A control write restarts the sequence. Afterwards the flag is 1 in transmit mode and 0 in receive mode, and beat counting starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (buffer reads have side effects) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| shift_tick_i | input | 1 | One-cycle shift tick from the clock timer |
| pin_i | input | PIN_W | Pin bus input |
| next_data_i | input | PIN_W | Output of the neighbouring shifter |
| pin_o | output | PIN_W | Pin bus output beat |
| pin_oe_o | output | 1 | Pin bus output enable |
| status_o | output | 1 | Status flag |
| timer_trig_o | output | 1 | Timer start trigger, high while the flag is clear |
| irq_o | output | 1 | Status interrupt |

## Verification
Register writes and ticks are applied across one rising edge. Their results (flag, trigger, interrupt, the next `pin_o` beat, the captured word) are due at that same edge, one cycle after the stimulus. The bench samples them at the following falling edge. Register reads are combinational, so the bench samples read data in the cycle the read strobe is high. It then checks the flag-clearing side effect one edge later. Random words and beat widths are mixed with directed cases:
- re-shift after a status clear;
- ticks after completion;
- the interrupt held past the end of a transfer;
- a mode change in the middle of a transfer.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = $clog2(WORD_W) + 1;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_IEN   = 3'd2,
    A_BUF   = 3'd3,
    A_BUFSW = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic [4:0] pw_m1;
    logic [1:0] pin_cfg;
    logic       src_next;
    logic       rx_mode;
  } ctrl_t;

  localparam logic [1:0] PIN_OUT = 2'd3;

  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/pds_regs.sv
module pds_regs
  import pds_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output ctrl_t             ctrl_o,
  output logic              ien_o,
  output logic              cfg_wr_o,
  output logic              cfg_rx_o,
  output logic              load_o,
  output logic [WORD_W-1:0] load_data_o,
  output logic              clr_o
);
  localparam logic [4:0] PW_MAX = 5'(PIN_W - 1);

  ctrl_t ctrl_q;
  logic  ien_q;
  logic  wr_ctrl, wr_stat, wr_ien, wr_buf, wr_bufsw, rd_buf;
  logic [4:0] pw_new;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_stat  = reg_we_i && (reg_addr_i == A_STAT);
  assign wr_ien   = reg_we_i && (reg_addr_i == A_IEN);
  assign wr_buf   = reg_we_i && (reg_addr_i == A_BUF);
  assign wr_bufsw = reg_we_i && (reg_addr_i == A_BUFSW);
  assign rd_buf   = reg_re_i && ((reg_addr_i == A_BUF) || (reg_addr_i == A_BUFSW));

  assign pw_new = (reg_wdata_i[8:4] > PW_MAX) ? PW_MAX : reg_wdata_i[8:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{pw_m1: PW_MAX, pin_cfg: 2'd0, src_next: 1'b0, rx_mode: 1'b0};
      ien_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= '{pw_m1: pw_new, pin_cfg: reg_wdata_i[3:2],
                    src_next: reg_wdata_i[1], rx_mode: reg_wdata_i[0]};
      end
      if (wr_ien) ien_q <= reg_wdata_i[0];
    end
  end

  assign ctrl_o      = ctrl_q;
  assign ien_o       = ien_q;
  assign cfg_wr_o    = wr_ctrl;
  assign cfg_rx_o    = reg_wdata_i[0];
  assign load_o      = (wr_buf || wr_bufsw) && !ctrl_q.rx_mode;
  assign load_data_o = wr_bufsw ? byte_rev(reg_wdata_i) : reg_wdata_i;
  // rx buffer reads consume the word; status write-1 always clears
  assign clr_o       = (wr_stat && reg_wdata_i[0]) || (rd_buf && ctrl_q.rx_mode);

  a_r5_pw_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.pw_m1 <= PW_MAX);
endmodule

// File: rtl/pds_engine.sv
module pds_engine
  import pds_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_mode_i,
  input  logic              src_next_i,
  input  logic [4:0]        pw_m1_i,
  input  logic [PIN_W-1:0]  pin_i,
  input  logic [PIN_W-1:0]  next_i,
  input  logic              tick_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_rx_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [PIN_W-1:0]  beat_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q, hold_q;
  logic [CNT_W-1:0]  bits_q, bw;
  logic              flag_q, last;
  logic [PIN_W-1:0]  mask, rx_in;
  logic [WORD_W-1:0] sh_tx, sh_rx, rx_in_w;
  logic [2*WORD_W-1:0] rx_cat;

  assign bw   = CNT_W'(pw_m1_i) + CNT_W'(1);
  assign last = ({1'b0, bits_q} + {1'b0, bw}) >= (CNT_W+1)'(WORD_W);

  for (genvar i = 0; i < PIN_W; i++) begin : g_mask
    assign mask[i] = bw > CNT_W'(i);
  end

  assign rx_in   = (src_next_i ? next_i : pin_i) & mask;
  assign rx_in_w = WORD_W'(rx_in);
  assign sh_tx   = sr_q >> bw;
  assign rx_cat  = {rx_in_w, sr_q} >> bw;
  assign sh_rx   = rx_cat[WORD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      hold_q <= '0;
      bits_q <= '0;
      flag_q <= 1'b1;
    end else if (cfg_wr_i) begin
      sr_q   <= '0;
      bits_q <= '0;
      flag_q <= !cfg_rx_i;
    end else if (load_i) begin
      hold_q <= load_data_i;
      sr_q   <= load_data_i;
      bits_q <= '0;
      flag_q <= 1'b0;
    end else if (clr_i) begin
      sr_q   <= rx_mode_i ? '0 : hold_q;
      bits_q <= '0;
      flag_q <= 1'b0;
    end else if (tick_i && !flag_q) begin
      sr_q <= rx_mode_i ? sh_rx : sh_tx;
      if (last) begin
        bits_q <= '0;
        flag_q <= 1'b1;
        if (rx_mode_i) hold_q <= sh_rx;
      end else begin
        bits_q <= bits_q + bw;
      end
    end
  end

  assign flag_o = flag_q;
  assign beat_o = rx_mode_i ? '0 : (sr_q[PIN_W-1:0] & mask);
  assign word_o = hold_q;

  a_r2_load_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !cfg_wr_i) |=> !flag_q);
  a_r4_bit_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_q < CNT_W'(WORD_W));
  a_r4_flag_sets_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !tick_i && !cfg_wr_i) |=> !flag_q);
  a_r6_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && rx_mode_i && !cfg_wr_i && !clr_i) |=> $stable(hold_q));
endmodule

// File: rtl/pds_shifter.sv
module pds_shifter
  import pds_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              shift_tick_i,
  input  logic [PIN_W-1:0]  pin_i,
  input  logic [PIN_W-1:0]  next_data_i,
  output logic [PIN_W-1:0]  pin_o,
  output logic              pin_oe_o,
  output logic              status_o,
  output logic              timer_trig_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic              ien, cfg_wr, cfg_rx, load, clr, flag;
  logic [WORD_W-1:0] load_data, word;

  pds_regs #(.PIN_W(PIN_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_re_i    (reg_re_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .ctrl_o      (ctrl),
    .ien_o       (ien),
    .cfg_wr_o    (cfg_wr),
    .cfg_rx_o    (cfg_rx),
    .load_o      (load),
    .load_data_o (load_data),
    .clr_o       (clr)
  );

  pds_engine #(.PIN_W(PIN_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_mode_i   (ctrl.rx_mode),
    .src_next_i  (ctrl.src_next),
    .pw_m1_i     (ctrl.pw_m1),
    .pin_i       (pin_i),
    .next_i      (next_data_i),
    .tick_i      (shift_tick_i),
    .cfg_wr_i    (cfg_wr),
    .cfg_rx_i    (cfg_rx),
    .load_i      (load),
    .load_data_i (load_data),
    .clr_i       (clr),
    .flag_o      (flag),
    .beat_o      (pin_o),
    .word_o      (word)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = 32'(ctrl);
      A_STAT:  reg_rdata_o = 32'(flag);
      A_IEN:   reg_rdata_o = 32'(ien);
      A_BUF:   reg_rdata_o = word;
      A_BUFSW: reg_rdata_o = byte_rev(word);
      default: reg_rdata_o = '0;
    endcase
  end

  assign pin_oe_o     = (ctrl.pin_cfg == PIN_OUT);
  assign status_o     = flag;
  assign timer_trig_o = !flag;
  assign irq_o        = flag && ien;

  // interrupt cannot drop without a register access
  a_r11_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_we_i && !reg_re_i) |=> irq_o);
  a_r2_trig_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(timer_trig_o && irq_o));
endmodule

// File: tb/tb_pds_shifter.sv
module tb_pds_shifter;
  localparam int PIN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             we = 1'b0, re = 1'b0, tick = 1'b0;
  logic [2:0]       addr = '0;
  logic [31:0]      wdata = '0, rdata;
  logic [PIN_W-1:0] pin_in = '0, next_in = '0, pin_out;
  logic             oe, status, trig, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pds_shifter #(.PIN_W(PIN_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .shift_tick_i(tick), .pin_i(pin_in),
    .next_data_i(next_in), .pin_o(pin_out), .pin_oe_o(oe), .status_o(status),
    .timer_trig_o(trig), .irq_o(irq)
  );

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] beat_of(input logic [31:0] w, input int b, input int k);
    return (w >> (k * b)) & ((32'd1 << b) - 32'd1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    re = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic tk();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tx_word(input logic [31:0] w, input int b, input bit swap);
    logic [31:0] e;
    e = swap ? rev(w) : w;
    wr(swap ? 3'd4 : 3'd3, w);
    chk("R2 flag clear", 32'(status), 0);
    chk("R2 trigger", 32'(trig), 1);
    for (int k = 0; k < 32 / b; k++) begin
      chk(swap ? "R10 swapped beat" : "R3/R5 beat", 32'(pin_out), beat_of(e, b, k));
      tk();
    end
    chk("R4 flag set", 32'(status), 1);
    chk("R4 trigger off", 32'(trig), 0);
  endtask

  task automatic rx_word(input logic [31:0] w, input int b, input bit from_next);
    for (int k = 0; k < 32 / b; k++) begin
      if (from_next) begin
        next_in = PIN_W'(beat_of(w, b, k));
        pin_in  = PIN_W'($urandom);
      end else begin
        pin_in = PIN_W'(beat_of(w, b, k)) | (b < PIN_W ? PIN_W'($urandom) << b : '0);
      end
      tk();
    end
    chk("R6 flag set", 32'(status), 1);
  endtask

  initial begin
    logic [31:0] v, w;
    int b;
    void'($urandom(32'd91));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 status", 32'(status), 1);
    chk("R1 trig", 32'(trig), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 oe", 32'(oe), 0);
    rd(3'd0, v); chk("R1 ctrl", v, 32'h70);
    rd(3'd2, v); chk("R1 ien", v, 0);

    wr(3'd0, 32'h7C);
    chk("R9 oe out", 32'(oe), 1);
    rd(3'd0, v); chk("R5 ctrl readback", v, 32'h7C);
    wr(3'd0, 32'h1FC);
    rd(3'd0, v); chk("R5 width clamp", v, 32'h7C);

    tx_word(32'h44332211, 8, 0);
    tk(); tk();
    chk("R4 ignore ticks pin", 32'(pin_out), 0);
    chk("R4 ignore ticks flag", 32'(status), 1);

    wr(3'd1, 32'h1);
    chk("R12 flag cleared", 32'(status), 0);
    chk("R12 reshift first beat", 32'(pin_out), 32'h11);
    tk();
    chk("R12 reshift second beat", 32'(pin_out), 32'h22);
    tk(); tk(); tk();
    chk("R12 done", 32'(status), 1);

    wr(3'd2, 32'h1);
    chk("R11 irq on", 32'(irq), 1);
    repeat (5) @(negedge clk);
    chk("R11 irq held", 32'(irq), 1);
    wr(3'd3, 32'hA5A5_5A5A);
    chk("R11 irq drops on load", 32'(irq), 0);
    repeat (4) tk();
    chk("R11 irq after last transfer", 32'(irq), 1);
    repeat (3) @(negedge clk);
    chk("R11 irq still held", 32'(irq), 1);
    wr(3'd2, 32'h0);
    chk("R11 irq masked", 32'(irq), 0);

    tx_word(32'h11223344, 8, 1);

    wr(3'd3, 32'hDEADBEEF);
    tk();
    wr(3'd0, 32'h7C);
    chk("R13 tx restart flag", 32'(status), 1);

    for (int n = 0; n < 12; n++) begin
      b = 1 << ($urandom % 4);
      wr(3'd0, (32'(b - 1) << 4) | 32'hC);
      w = $urandom;
      tx_word(w, b, n[0]);
    end

    wr(3'd0, 32'h71);
    chk("R13 rx restart flag", 32'(status), 0);
    chk("R9 oe input", 32'(oe), 0);
    chk("R2 trig in rx", 32'(trig), 1);
    rx_word(32'hCAFE_1234, 8, 0);
    tk(); pin_in = 8'hFF; tk();
    rd(3'd3, v); chk("R6 word held", v, 32'hCAFE_1234);
    chk("R7 read clears", 32'(status), 0);

    for (int n = 0; n < 10; n++) begin
      b = 1 << ($urandom % 4);
      wr(3'd0, (32'(b - 1) << 4) | 32'h1);
      w = $urandom;
      rx_word(w, b, 0);
      if (n[0]) begin
        rd(3'd4, v); chk("R10 swapped read", v, rev(w));
      end else begin
        rd(3'd3, v); chk("R6 rx word", v, w);
      end
      chk("R7 read clears", 32'(status), 0);
    end

    wr(3'd0, 32'h73);
    rx_word(32'h0BAD_F00D, 8, 1);
    rd(3'd3, v); chk("R8 next source", v, 32'h0BAD_F00D);
    wr(3'd0, 32'h31);
    rx_word(32'h9876_5432, 4, 0);
    rd(3'd3, v); chk("R5 4-bit beats", v, 32'h9876_5432);

    wr(3'd2, 32'h1);
    rx_word(32'h1357_9BDF, 4, 0);
    chk("R11 rx irq", 32'(irq), 1);
    wr(3'd1, 32'h1);
    chk("R12 status clear rx", 32'(status), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule